// File: doc/BRIEF.md
# Management Bus Access Sequencer

This block sits between user logic and a register management bus. The bus has a 16-bit address, 32-bit write data, 32-bit read data, separate read and write strobes, and a read-data-valid return from the slave. User logic presents one access at a time: an address, write data and a direction bit, qualified by a valid signal. It waits for ready. The sequencer then drives a correctly timed bus transaction. It holds each strobe for at least two cycles and keeps the address and data steady for as long as the strobe is high. It leaves the strobes low between accesses, and it registers the returned read word.

Each completed access ends with a single-cycle done pulse. A read whose data-valid never arrives is ended after a configurable number of strobe cycles. It then completes with an error flag and an all-zero word. Bursts and pipelined accesses are not supported. Only one access is outstanding at any time.

Top module: `mbus_seq`

## Requirements
- R1: A write drives the write strobe high for exactly two consecutive cycles, and the read strobe stays low throughout.
- R2: A read raises the read strobe and holds it until the cycle in which the slave's data-valid is high. The minimum is two cycles: with a slave that answers one cycle after the strobe rises, the strobe is high for exactly two cycles, and with a latency of L cycles (L < READ_TIMEOUT) it is high for L+1 cycles.
- R3: The read and write strobes are never high in the same cycle. A strobe only rises after a cycle in which both strobes were low and the sequencer was ready.
- R4: While either strobe is high, the bus address equals the accepted request address. During a write, the bus write data also equals the accepted request data. Both are stable for the whole strobe window.
- R5: A request is taken on a clock edge where req_valid and req_ready are both 1. Ready goes low in the following cycle and stays low through the strobe cycles and the done cycle. It returns high in the cycle right after the done pulse. Ready is never high while a strobe is high.
- R6: On a successful read, rsp_rdata takes the bus read word from the cycle where data-valid was high. It presents that word together with a one-cycle done pulse in the cycle right after the last strobe cycle, and rsp_err is 0 then.
- R7: A write completes with a one-cycle done pulse in the cycle right after its second strobe cycle, with rsp_err 0. rsp_rdata is left unchanged by writes.
- R8: If data-valid has not been seen by the READ_TIMEOUT-th read strobe cycle, the strobe drops after exactly READ_TIMEOUT cycles. The done pulse then comes with rsp_err = 1 and rsp_rdata = 0. A data-valid in the READ_TIMEOUT-th cycle still counts as success.
- R9: rsp_err is high only in a done cycle, and only for a timed-out read.
- R10: A synchronous active-high reset drops both strobes at the next edge. It clears done, rsp_err and rsp_rdata, and returns the sequencer to idle with req_ready at 1, even in the middle of an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Request write data |
| done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Read timeout flag, valid with done |
| rsp_rdata | output | DATA_W | Last captured read word |
| bus_read | output | 1 | Read strobe to the management bus |
| bus_write | output | 1 | Write strobe to the management bus |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdata | input | DATA_W | Bus read data from the slave |
| bus_rvalid | input | 1 | Slave read-data-valid |

## Verification
A corrupted sequencer state shows up at the bus within the access that suffers it. Examples are a strobe that lasts one cycle or runs past its bound, a done pulse that is not in the first low cycle, or ready that returns early or late. The bench measures every strobe window against the expected length for that access's direction and slave latency. It checks each done cycle's flag and word, and it checks ready in the cycle after done, so a fault is reported within a few cycles of the access that exposed it. A stale or wrong latch of address, data or read word shows up as a mismatch at the bus in the first strobe cycle, or at rsp_rdata in the done cycle.

// File: rtl/mbus_seq_pkg.sv
package mbus_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HOLD1 = 3'd1,
    ST_HOLD2 = 3'd2,
    ST_RWAIT = 3'd3,
    ST_GAP   = 3'd4
  } seq_state_t;

endpackage

// File: rtl/mbus_seq_timer.sv
module mbus_seq_timer #(
  parameter int READ_TIMEOUT = 8,
  parameter int CNT_W        = $clog2(READ_TIMEOUT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic expire
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(READ_TIMEOUT - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (run && cnt != LAST + CNT_W'(1)) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign expire = (cnt == LAST);

endmodule

// File: rtl/mbus_seq_path.sv
module mbus_seq_path #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              capture,
  input  logic              zero_rd,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rsp_rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else if (accept) begin
      bus_addr  <= req_addr;
      bus_wdata <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_rdata <= '0;
    end else if (capture) begin
      rsp_rdata <= bus_rdata;
    end else if (zero_rd) begin
      rsp_rdata <= '0;
    end
  end

endmodule

// File: rtl/mbus_seq_ctrl.sv
module mbus_seq_ctrl
  import mbus_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic req_write,
  input  logic bus_rvalid,
  input  logic tmr_expire,
  output logic req_ready,
  output logic accept,
  output logic strobe_rd,
  output logic strobe_wr,
  output logic done,
  output logic err,
  output logic capture,
  output logic zero_rd
);

  seq_state_t state;
  logic       is_wr;
  logic       waiting_rd;

  assign accept     = req_valid && req_ready;
  assign waiting_rd = (state == ST_HOLD2 || state == ST_RWAIT) && !is_wr;
  assign capture    = waiting_rd && bus_rvalid;
  assign zero_rd    = waiting_rd && !bus_rvalid && tmr_expire;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      req_ready <= 1'b1;
      strobe_rd <= 1'b0;
      strobe_wr <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      is_wr     <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            req_ready <= 1'b0;
            is_wr     <= req_write;
            strobe_wr <= req_write;
            strobe_rd <= !req_write;
            state     <= ST_HOLD1;
          end
        end
        ST_HOLD1: begin
          state <= ST_HOLD2;
        end
        ST_HOLD2, ST_RWAIT: begin
          if (is_wr) begin
            strobe_wr <= 1'b0;
            done      <= 1'b1;
            state     <= ST_GAP;
          end else if (capture) begin
            strobe_rd <= 1'b0;
            done      <= 1'b1;
            state     <= ST_GAP;
          end else if (zero_rd) begin
            strobe_rd <= 1'b0;
            done      <= 1'b1;
            err       <= 1'b1;
            state     <= ST_GAP;
          end else begin
            state <= ST_RWAIT;
          end
        end
        ST_GAP: begin
          req_ready <= 1'b1;
          state     <= ST_IDLE;
        end
        default: begin
          state     <= ST_IDLE;
          req_ready <= 1'b1;
          strobe_rd <= 1'b0;
          strobe_wr <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/mbus_seq.sv
module mbus_seq #(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 32,
  parameter int READ_TIMEOUT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_read,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_rvalid
);

  localparam int CNT_W = $clog2(READ_TIMEOUT + 1);

  logic accept;
  logic capture;
  logic zero_rd;
  logic tmr_expire;

  mbus_seq_ctrl ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .bus_rvalid (bus_rvalid),
    .tmr_expire (tmr_expire),
    .req_ready  (req_ready),
    .accept     (accept),
    .strobe_rd  (bus_read),
    .strobe_wr  (bus_write),
    .done       (done),
    .err        (rsp_err),
    .capture    (capture),
    .zero_rd    (zero_rd)
  );

  mbus_seq_timer #(
    .READ_TIMEOUT (READ_TIMEOUT),
    .CNT_W        (CNT_W)
  ) timer_i (
    .clk    (clk),
    .rst    (rst),
    .clear  (accept),
    .run    (bus_read),
    .expire (tmr_expire)
  );

  mbus_seq_path #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) path_i (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .capture   (capture),
    .zero_rd   (zero_rd),
    .bus_rdata (bus_rdata),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rsp_rdata (rsp_rdata)
  );

endmodule

// File: rtl/mbus_seq_chk.sv
module mbus_seq_chk #(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 32,
  parameter int READ_TIMEOUT = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              done,
  input logic              rsp_err,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              bus_read,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata
);

  localparam int LEN_W = $clog2(READ_TIMEOUT + 2);

  logic             past_rst = 1'b0;
  logic [LEN_W-1:0] rd_len;
  logic [1:0]       wr_len;
  logic             strobe_any;

  assign strobe_any = bus_read || bus_write;

  always_ff @(posedge clk) begin
    past_rst <= rst;
    if (rst) begin
      rd_len <= '0;
      wr_len <= '0;
    end else begin
      rd_len <= bus_read  ? rd_len + LEN_W'(1) : '0;
      wr_len <= bus_write ? ((wr_len == 2'd3) ? wr_len : wr_len + 2'd1) : 2'd0;
    end
  end

  // R1: write strobe stretched to a second cycle, and never a third
  p_wr_hold_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_write) |=> bus_write);
  p_wr_len_r1: assert property (@(posedge clk) disable iff (rst)
    bus_write |-> wr_len < 2'd2);

  // R2: read strobe stretched to at least two cycles
  p_rd_hold_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_read) |=> bus_read);

  // R3: exclusivity and idle cycle before a rise
  p_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(bus_read && bus_write));
  p_rise_idle_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(strobe_any) |-> $past(req_ready) && !$past(strobe_any));

  // R4: address and data steady during a strobe window
  p_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (strobe_any && $past(strobe_any)) |-> ($stable(bus_addr) && $stable(bus_wdata)));

  // R5: handshake
  p_ready_drop_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  p_ready_idle_r5: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !strobe_any);

  // R6 / R7: done right after last strobe cycle, single cycle
  p_done_place_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(strobe_any) && !strobe_any));
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: bounded read strobe, error word zero
  p_rd_len_r8: assert property (@(posedge clk) disable iff (rst)
    bus_read |-> rd_len < LEN_W'(READ_TIMEOUT));
  p_err_zero_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> rsp_rdata == '0);

  // R9: error only alongside done
  p_err_done_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> done);

  // R10: reset state one edge after reset
  p_reset_r10: assert property (@(posedge clk)
    past_rst |-> (!bus_read && !bus_write && !done && !rsp_err && req_ready));

endmodule

bind mbus_seq mbus_seq_chk #(
  .ADDR_W       (ADDR_W),
  .DATA_W       (DATA_W),
  .READ_TIMEOUT (READ_TIMEOUT)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .done      (done),
  .rsp_err   (rsp_err),
  .rsp_rdata (rsp_rdata),
  .bus_read  (bus_read),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata)
);

// File: tb/mbus_seq_tb.sv
module mbus_seq_tb_top;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int TO = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          done;
  logic          rsp_err;
  logic [DW-1:0] rsp_rdata;
  logic          bus_read;
  logic          bus_write;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata = '0;
  logic          bus_rvalid = 1'b0;

  int n_chk  = 0;
  int n_fail = 0;
  int slv_lat = 1;
  int scnt = 0;
  logic [DW-1:0] model_rdata = '0;
  bit finished = 0;

  always #2 clk = ~clk;

  mbus_seq #(.ADDR_W(AW), .DATA_W(DW), .READ_TIMEOUT(TO)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .bus_read(bus_read), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  function automatic logic [DW-1:0] slv_word(input logic [AW-1:0] a);
    return {a ^ 16'hC3A5, ~a} + 32'h0101_0101;
  endfunction

  // Slave model: data-valid slv_lat cycles after the read strobe rises (0 = never)
  always @(posedge clk) begin
    if (!bus_read) begin
      scnt       <= 0;
      bus_rvalid <= 1'b0;
      bus_rdata  <= 32'hDEAD_BEEF;
    end else begin
      scnt       <= scnt + 1;
      bus_rvalid <= (slv_lat != 0) && (scnt + 1 == slv_lat);
      bus_rdata  <= slv_word(bus_addr);
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: strobes never both high (R3)
  always @(negedge clk) begin
    if (!rst && bus_read && bus_write)
      check(1'b0, "R3 both strobes high", 64'd1, 64'd0);
  end

  task automatic run_txn(input bit wr, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input int lat);
    int n;
    bit ok_rd;
    int exp_len;
    logic [DW-1:0] exp_word;
    slv_lat = lat;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = ~a;
    req_wdata = ~d;
    check(!req_ready, "R5 ready low after accept", {63'd0, req_ready}, 64'd0);
    n = 0;
    while ((bus_read || bus_write) && n < 64) begin
      check(bus_addr == a, "R4 bus address", {48'd0, bus_addr}, {48'd0, a});
      if (wr) begin
        check(bus_wdata == d, "R4 bus write data", {32'd0, bus_wdata}, {32'd0, d});
        check(bus_write && !bus_read, "R1 write strobe only", {62'd0, bus_write, bus_read}, 64'd2);
      end else begin
        check(bus_read && !bus_write, "R2 read strobe only", {62'd0, bus_write, bus_read}, 64'd1);
      end
      if (done || req_ready)
        check(1'b0, "R5 done/ready during strobe", {62'd0, done, req_ready}, 64'd0);
      n++;
      @(negedge clk);
    end
    ok_rd    = (lat >= 1) && (lat <= TO - 1);
    exp_len  = wr ? 2 : (ok_rd ? lat + 1 : TO);
    if (wr)
      check(n == exp_len, "R1 write strobe length", 64'(n), 64'(exp_len));
    else if (ok_rd)
      check(n == exp_len, "R2 read strobe length", 64'(n), 64'(exp_len));
    else
      check(n == exp_len, "R8 timeout strobe length", 64'(n), 64'(exp_len));
    check(done == 1'b1, wr ? "R7 write done pulse" : "R6 read done pulse",
          {63'd0, done}, 64'd1);
    if (wr) begin
      check(rsp_err == 1'b0, "R9 no error on write", {63'd0, rsp_err}, 64'd0);
      check(rsp_rdata == model_rdata, "R7 rdata unchanged by write",
            {32'd0, rsp_rdata}, {32'd0, model_rdata});
    end else if (ok_rd) begin
      exp_word = slv_word(a);
      model_rdata = exp_word;
      check(rsp_err == 1'b0, "R9 no error on good read", {63'd0, rsp_err}, 64'd0);
      check(rsp_rdata == exp_word, "R6 captured read word",
            {32'd0, rsp_rdata}, {32'd0, exp_word});
    end else begin
      model_rdata = '0;
      check(rsp_err == 1'b1, "R8 timeout error flag", {63'd0, rsp_err}, 64'd1);
      check(rsp_rdata == '0, "R8 timeout zero word", {32'd0, rsp_rdata}, 64'd0);
    end
    check(!bus_read && !bus_write, "R3 strobes low in done cycle",
          {62'd0, bus_write, bus_read}, 64'd0);
    check(!req_ready, "R5 ready low in done cycle", {63'd0, req_ready}, 64'd0);
    @(negedge clk);
    check(!done, "R7 done single cycle", {63'd0, done}, 64'd0);
    check(!rsp_err, "R9 error cleared after done", {63'd0, rsp_err}, 64'd0);
    check(req_ready, "R5 ready back after done", {63'd0, req_ready}, 64'd1);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(req_ready && !bus_read && !bus_write && !done && !rsp_err,
          "R10 reset state", {59'd0, req_ready, bus_read, bus_write, done, rsp_err}, 64'h10);
    check(rsp_rdata == '0, "R10 reset read word", {32'd0, rsp_rdata}, 64'd0);

    // Directed corners
    run_txn(1'b1, 16'h0012, 32'hA5A5_0001, 1);
    run_txn(1'b1, 16'h0013, 32'h5A5A_0002, 1);
    run_txn(1'b0, 16'h0000, 32'h0, 1);
    run_txn(1'b0, 16'h0001, 32'h0, 1);
    run_txn(1'b1, 16'hFFFF, 32'hFFFF_FFFF, 1);
    run_txn(1'b0, 16'h0042, 32'h0, TO - 1);
    run_txn(1'b0, 16'h0043, 32'h0, TO);
    run_txn(1'b0, 16'h0044, 32'h0, 0);
    run_txn(1'b0, 16'h0045, 32'h0, 3);

    // Constrained random mix
    for (int i = 0; i < 80; i++) begin
      bit wr;
      int r;
      int lat;
      wr = 1'($urandom % 2);
      r  = int'($urandom % 10);
      if (r < 6)      lat = 1;
      else if (r < 8) lat = 2 + int'($urandom % (TO - 2));
      else if (r < 9) lat = TO;
      else            lat = 0;
      run_txn(wr, 16'($urandom), $urandom, lat);
    end

    // Reset in the middle of a read
    slv_lat = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_write = 1'b0;
    req_addr  = 16'h0777;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check(bus_read, "R2 read strobe before reset", {63'd0, bus_read}, 64'd1);
    rst = 1'b1;
    @(negedge clk);
    check(!bus_read && !bus_write, "R10 strobes dropped by reset",
          {62'd0, bus_write, bus_read}, 64'd0);
    check(req_ready && !done && !rsp_err && rsp_rdata == '0, "R10 idle after reset",
          {61'd0, req_ready, done, rsp_err}, 64'd4);
    rst = 1'b0;
    model_rdata = '0;
    run_txn(1'b0, 16'h0778, 32'h0, 1);
    run_txn(1'b1, 16'h0779, 32'h1234_5678, 1);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule